// File: doc/BRIEF.md
# Power-Fail Critical Byte Saver

This block sits between a supply monitor and a byte-wide nonvolatile memory port. It watches two early-warning sources: a comparator flag that rises when the unregulated input sags, and a mains-derived input that toggles once per line cycle. When the flag is seen, or when the mains input stops toggling for a full timeout window, the block has only the hold-up time of the supply capacitor left. In that time it turns off every drive output it controls, takes a snapshot of the critical bytes and of the save-area strap, and writes the bytes one at a time into the memory. Each write takes on the order of ten milliseconds.

The save area starts at an address chosen by a 3-bit board strap. Each write goes through a request/busy/done handshake, and the next byte goes out only after the memory has reported completion of the current one. When the last byte has been written the block freezes in a halt state. From then on it issues nothing and ignores every input until reset, so a decaying supply cannot cause a stray write.

Top module: `pwrfail_saver`

## Requirements
- R1: While reset is held and on the first cycle after it, `drive_en_o` is 1, `nv_req_o` is 0 and `halted_o` is 0.
- R2: A rise on `fail_warn_i` passes through a two-flop synchronizer. `drive_en_o` falls at the third rising clock edge after the warning is applied. `nv_req_o` is never 1 while `drive_en_o` is 1.
- R3: `mains_tick_i` counts as alive when it changes level at least once in every window of WINDOW_MS × (CLK_HZ/1000) clock cycles. If no change occurs in a whole window, a power failure is declared. A toggle every 100 cycles against a 320-cycle window must never trigger a save.
- R4: The strap code sets the start address S: 0→0, 1→2, 2→5. Codes 3 to 7 come from a parameter table whose default is 3→8, 4→11, 5→14, 6→17, 7→20. Byte k is written at address S+k.
- R5: Byte k of the save is `crit_data_i[8k+7:8k]`. The bytes are written in ascending order of k, from 0 to NBYTES-1.
- R6: `nv_req_o` rises only in a cycle after `nv_busy_i` was 0. Once raised, it stays high with `nv_addr_o` and `nv_data_o` unchanged until `nv_done_i` is seen. Only after that can the next request be made.
- R7: Exactly NBYTES requests are made per save (default 4). After the last `nv_done_i`, `halted_o` goes to 1 and stays there, and no further request occurs until reset.
- R8: The bytes and the strap are captured in the cycle the failure is detected. Any later change on `crit_data_i` or `addr_sel_i` does not alter what is written.
- R9: A warning that is removed and reasserted during a save, or after the halt, has no effect on the writes, the addresses or the outputs. `drive_en_o` stays 0 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fail_warn_i | input | 1 | Asynchronous supply-sag warning flag, high = failing |
| mains_tick_i | input | 1 | Asynchronous input that toggles once per mains cycle |
| addr_sel_i | input | 3 | Strap code that selects the save-area start address |
| crit_data_i | input | NBYTES*8 | Critical bytes to save; byte k is bits 8k+7:8k |
| nv_busy_i | input | 1 | Memory is busy and must not be given a request |
| nv_done_i | input | 1 | One-cycle pulse: the current write has completed |
| drive_en_o | output | 1 | Drive enable for board outputs; 0 = safe, non-driving |
| nv_req_o | output | 1 | Write request, held until done |
| nv_addr_o | output | ADDR_W | Write address |
| nv_data_o | output | 8 | Write data byte |
| halted_o | output | 1 | Save complete; block is frozen until reset |

## Verification
The assertions assume that the memory raises `nv_done_i` only while a request is pending, and as a single pulse, and that it never drops a request. The bench memory model waits for a request, holds busy for a set latency, pulses done once, and then waits for the next request. It also assumes `nv_busy_i` can be held high from outside. The bench does this in one test by forcing busy from the outside, and it releases busy only after it has checked that no request leaked out.

// File: rtl/pfs_pkg.sv
// Package: shared types for the power-fail save sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package pfs_pkg;

    // Sequencer states; ST_HALT is terminal until reset.
    typedef enum logic [2:0] {
        ST_MONITOR = 3'd0,
        ST_SAFE    = 3'd1,
        ST_ISSUE   = 3'd2,
        ST_WAIT    = 3'd3,
        ST_HALT    = 3'd4
    } pfs_state_e;

    // Number of strap codes that go through the parameter table (codes 3..7).
    localparam int unsigned XTAB_ENTRIES = 5;

endpackage

// File: rtl/pfs_sync.sv
// Module: pfs_sync
// Purpose: two-flop synchronizer for a vector of independent asynchronous bits.
// Assumes: every bit is a slow level or toggle, so no bus coherence is needed.
module pfs_sync #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Two-stage capture into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;

endmodule

// File: rtl/pfs_mains_watch.sv
// Module: pfs_mains_watch
// Purpose: declares mains loss when the synchronized mains toggle input does
//          not change level for WINDOW_MS milliseconds.
// Assumes: CYC_PER_MS clock cycles make one millisecond; the input is already
//          synchronized. After reset the window starts running at once.
module pfs_mains_watch #(
    parameter int unsigned CYC_PER_MS = 50_000,
    parameter int unsigned WINDOW_MS  = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mains_s_i,
    output logic lost_o
);

    localparam int unsigned PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam int unsigned MW = $clog2(WINDOW_MS + 1);
    localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_MS - 1);
    localparam logic [MW-1:0] MS_LIMIT = MW'(WINDOW_MS);

    logic          prev_q;
    logic          edge_seen;
    logic [PW-1:0] pre_q;
    logic [MW-1:0] ms_q;

    // Remember the last sampled mains level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= mains_s_i;
    end

    assign edge_seen = mains_s_i ^ prev_q;

    // Millisecond prescaler and window counter; any edge restarts both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (edge_seen) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (ms_q != MS_LIMIT) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                ms_q  <= ms_q + MW'(1);
            end else begin
                pre_q <= pre_q + PW'(1);
            end
        end
    end

    assign lost_o = (ms_q == MS_LIMIT);

endmodule

// File: rtl/pfs_base_sel.sv
// Module: pfs_base_sel
// Purpose: maps the 3-bit strap code to the save-area start address.
// Assumes: codes 0..2 are fixed; codes 3..7 read an 8-bit-per-entry table,
//          lowest entry for code 3.
module pfs_base_sel #(
    parameter int unsigned ADDR_W = 8,
    parameter logic [pfs_pkg::XTAB_ENTRIES*8-1:0] XTAB =
        {8'd20, 8'd17, 8'd14, 8'd11, 8'd8}
) (
    input  logic [2:0]        code_i,
    output logic [ADDR_W-1:0] base_o
);

    logic [7:0] tab_entry;

    // Table lookup for the parameterised codes.
    always_comb begin
        tab_entry = 8'd0;
        for (int i = 0; i < int'(pfs_pkg::XTAB_ENTRIES); i++) begin
            if (int'(code_i) == i + 3) tab_entry = XTAB[i*8 +: 8];
        end
    end

    // Fixed codes first, table for the rest.
    always_comb begin
        case (code_i)
            3'd0:    base_o = ADDR_W'(0);
            3'd1:    base_o = ADDR_W'(2);
            3'd2:    base_o = ADDR_W'(5);
            default: base_o = ADDR_W'(tab_entry);
        endcase
    end

endmodule

// File: rtl/pfs_seq.sv
// Module: pfs_seq
// Purpose: on failure, makes outputs safe, snapshots data and base address,
//          writes each byte through a req/busy/done handshake, then halts.
// Assumes: done is a single-cycle pulse given only while req is high.
module pfs_seq #(
    parameter int unsigned NBYTES = 4,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  trig_i,
    input  logic [NBYTES*8-1:0]   data_i,
    input  logic [ADDR_W-1:0]     base_i,
    input  logic                  busy_i,
    input  logic                  done_i,
    output logic                  drive_en_o,
    output logic                  req_o,
    output logic [ADDR_W-1:0]     addr_o,
    output logic [7:0]            data_o,
    output logic                  halted_o
);

    import pfs_pkg::*;

    localparam int unsigned IW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [IW-1:0] IDX_LAST = IW'(NBYTES - 1);

    pfs_state_e            state_q;
    logic [IW-1:0]         idx_q;
    logic [NBYTES*8-1:0]   snap_q;
    logic [ADDR_W-1:0]     base_q;

    // Save sequence state machine with registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_MONITOR;
            idx_q      <= '0;
            snap_q     <= '0;
            base_q     <= '0;
            drive_en_o <= 1'b1;
            req_o      <= 1'b0;
            addr_o     <= '0;
            data_o     <= '0;
        end else begin
            case (state_q)
                ST_MONITOR: begin
                    if (trig_i) begin
                        snap_q     <= data_i;
                        base_q     <= base_i;
                        drive_en_o <= 1'b0;
                        state_q    <= ST_SAFE;
                    end
                end
                ST_SAFE: begin
                    state_q <= ST_ISSUE;
                end
                ST_ISSUE: begin
                    if (!busy_i) begin
                        req_o   <= 1'b1;
                        addr_o  <= base_q + ADDR_W'(idx_q);
                        data_o  <= snap_q[idx_q*8 +: 8];
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (done_i) begin
                        req_o <= 1'b0;
                        if (idx_q == IDX_LAST) begin
                            state_q <= ST_HALT;
                        end else begin
                            idx_q   <= idx_q + IW'(1);
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_HALT: begin
                    state_q <= ST_HALT;
                end
                default: begin
                    state_q <= ST_HALT;
                end
            endcase
        end
    end

    assign halted_o = (state_q == ST_HALT);

endmodule

// File: rtl/pwrfail_saver.sv
// Module: pwrfail_saver (top)
// Purpose: power-fail critical byte saver; joins synchronizers, mains-loss
//          timer, strap decode and the save sequencer.
// Assumes: CLK_HZ is a multiple of 1000; the memory follows req/busy/done.
module pwrfail_saver #(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned WINDOW_MS = 32,
    parameter int unsigned NBYTES    = 4,
    parameter int unsigned ADDR_W    = 8,
    parameter logic [pfs_pkg::XTAB_ENTRIES*8-1:0] XTAB =
        {8'd20, 8'd17, 8'd14, 8'd11, 8'd8}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fail_warn_i,
    input  logic                  mains_tick_i,
    input  logic [2:0]            addr_sel_i,
    input  logic [NBYTES*8-1:0]   crit_data_i,
    input  logic                  nv_busy_i,
    input  logic                  nv_done_i,
    output logic                  drive_en_o,
    output logic                  nv_req_o,
    output logic [ADDR_W-1:0]     nv_addr_o,
    output logic [7:0]            nv_data_o,
    output logic                  halted_o
);

    localparam int unsigned CYC_PER_MS = CLK_HZ / 1000;

    logic [1:0]        sync_bits;
    logic              warn_s;
    logic              mains_s;
    logic              mains_lost;
    logic              trig;
    logic [ADDR_W-1:0] base_addr;

    pfs_sync #(.W(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({mains_tick_i, fail_warn_i}),
        .sync_o  (sync_bits)
    );

    assign warn_s  = sync_bits[0];
    assign mains_s = sync_bits[1];

    pfs_mains_watch #(
        .CYC_PER_MS (CYC_PER_MS),
        .WINDOW_MS  (WINDOW_MS)
    ) u_mains (
        .clk       (clk),
        .rst_n     (rst_n),
        .mains_s_i (mains_s),
        .lost_o    (mains_lost)
    );

    pfs_base_sel #(
        .ADDR_W (ADDR_W),
        .XTAB   (XTAB)
    ) u_base (
        .code_i (addr_sel_i),
        .base_o (base_addr)
    );

    // Either warning source starts the save.
    assign trig = warn_s | mains_lost;

    pfs_seq #(
        .NBYTES (NBYTES),
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_i     (trig),
        .data_i     (crit_data_i),
        .base_i     (base_addr),
        .busy_i     (nv_busy_i),
        .done_i     (nv_done_i),
        .drive_en_o (drive_en_o),
        .req_o      (nv_req_o),
        .addr_o     (nv_addr_o),
        .data_o     (nv_data_o),
        .halted_o   (halted_o)
    );

endmodule

// File: rtl/pfs_checker.sv
// Module: pfs_checker
// Purpose: protocol and sequencing properties of pwrfail_saver, bound to it.
// Assumes: memory done is a single pulse while a request is pending.
module pfs_checker #(
    parameter int unsigned NBYTES = 4,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nv_busy_i,
    input logic              nv_done_i,
    input logic              drive_en_o,
    input logic              nv_req_o,
    input logic [ADDR_W-1:0] nv_addr_o,
    input logic [7:0]        nv_data_o,
    input logic              halted_o
);

    logic       req_q;
    logic [7:0] issued_q;

    // Count request rising edges since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q    <= 1'b0;
            issued_q <= '0;
        end else begin
            req_q <= nv_req_o;
            if (nv_req_o && !req_q) issued_q <= issued_q + 8'd1;
        end
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> drive_en_o && !nv_req_o && !halted_o);

    p_safe_before_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req_o |-> !drive_en_o);

    p_req_after_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_req_o) |-> !$past(nv_busy_i));

    p_req_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req_o && !nv_done_i |=> nv_req_o && $stable(nv_addr_o) && $stable(nv_data_o));

    p_req_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        issued_q <= 8'(NBYTES));

    p_halt_complete_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> issued_q == 8'(NBYTES) && !nv_req_o);

    p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> halted_o);

    p_safe_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en_o |=> !drive_en_o);

endmodule

bind pwrfail_saver pfs_checker #(
    .NBYTES (NBYTES),
    .ADDR_W (ADDR_W)
) u_pfs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .nv_busy_i  (nv_busy_i),
    .nv_done_i  (nv_done_i),
    .drive_en_o (drive_en_o),
    .nv_req_o   (nv_req_o),
    .nv_addr_o  (nv_addr_o),
    .nv_data_o  (nv_data_o),
    .halted_o   (halted_o)
);

// File: tb/test_pwrfail_saver.sv
module test_pwrfail_saver;

    localparam int unsigned NB     = 4;
    localparam int unsigned AW     = 8;
    localparam int unsigned WIN_MS = 32;
    // 10 cycles per ms -> 320-cycle mains window
    localparam int unsigned HZ     = 10_000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          warn = 1'b0;
    logic          mains = 1'b0;
    logic [2:0]    sel = 3'd0;
    logic [NB*8-1:0] cdata = '0;
    logic          busy_w = 1'b0;
    logic          hold_busy = 1'b0;
    logic          nv_busy;
    logic          nv_done = 1'b0;
    logic          drive_en, nv_req, halted;
    logic [AW-1:0] nv_addr;
    logic [7:0]    nv_data;

    int checks = 0;
    int fails = 0;
    int wr_cnt = 0;
    int lat = 3;
    int mcnt = 0;
    logic mains_run = 1'b1;
    logic [AW-1:0] wr_addr [16];
    logic [7:0]    wr_data [16];

    assign nv_busy = busy_w | hold_busy;

    always #10 clk = ~clk;   // 50 MHz

    pwrfail_saver #(
        .CLK_HZ (HZ), .WINDOW_MS (WIN_MS), .NBYTES (NB), .ADDR_W (AW)
    ) i_pwrfail_saver (
        .clk (clk), .rst_n (rst_n), .fail_warn_i (warn), .mains_tick_i (mains),
        .addr_sel_i (sel), .crit_data_i (cdata), .nv_busy_i (nv_busy),
        .nv_done_i (nv_done), .drive_en_o (drive_en), .nv_req_o (nv_req),
        .nv_addr_o (nv_addr), .nv_data_o (nv_data), .halted_o (halted)
    );

    // stimulus/expect table: {sel[3], src (0 warn,1 mains), lat[4], data[32]}
    localparam logic [39:0] VEC [6] = '{
        {3'd0, 1'b0, 4'd2, 32'hA1B2C3D4},
        {3'd1, 1'b0, 4'd5, 32'h01020304},
        {3'd2, 1'b1, 4'd3, 32'hFF00AA55},
        {3'd3, 1'b0, 4'd1, 32'h12345678},
        {3'd5, 1'b1, 4'd7, 32'hDEADBEEF},
        {3'd7, 1'b0, 4'd4, 32'h0F1E2D3C}
    };

    function automatic int exp_start(input logic [2:0] c);
        return (c == 3'd0) ? 0 : 3 * int'(c) - 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // mains toggler: one level change every 100 cycles while running
    initial forever begin
        @(negedge clk);
        if (mains_run) begin
            mcnt++;
            if (mcnt >= 100) begin mains = ~mains; mcnt = 0; end
        end else mcnt = 0;
    end

    // memory model: accepts a request, stays busy for lat cycles, pulses done
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (nv_done) nv_done = 1'b0;
            else if (busy_w) begin
                if (cnt == 0) begin busy_w = 1'b0; nv_done = 1'b1; end
                else cnt--;
            end else if (nv_req && !hold_busy) begin
                busy_w = 1'b1;
                cnt = lat;
                if (wr_cnt < 16) begin
                    wr_addr[wr_cnt] = nv_addr;
                    wr_data[wr_cnt] = nv_data;
                end
                wr_cnt++;
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; warn = 1'b0; mains_run = 1'b1; hold_busy = 1'b0;
        repeat (4) @(negedge clk);
        wr_cnt = 0;
        rst_n = 1'b1;
    endtask

    task automatic wait_halt(input string req);
        int n = 0;
        while (!halted && n < 3000) begin @(negedge clk); n++; end
        check(halted == 1'b1, req, int'(halted), 1);
    endtask

    task automatic check_writes(input logic [2:0] c, input logic [31:0] d, input string req);
        check(wr_cnt == NB, "R7 write count", wr_cnt, NB);
        for (int k = 0; k < NB && k < wr_cnt; k++) begin
            check(int'(wr_addr[k]) == exp_start(c) + k, "R4 address", int'(wr_addr[k]), exp_start(c) + k);
            check(wr_data[k] == d[k*8 +: 8], req, int'(wr_data[k]), int'(d[k*8 +: 8]));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        check(drive_en == 1'b1, "R1 drive_en", int'(drive_en), 1);
        check(nv_req == 1'b0, "R1 req", int'(nv_req), 0);
        check(halted == 1'b0, "R1 halted", int'(halted), 0);

        // R3 live mains: no save over 1000 cycles
        repeat (1000) @(negedge clk);
        check(drive_en == 1'b1 && wr_cnt == 0, "R3 no false mains loss", wr_cnt, 0);

        // table walk: R2/R3 trigger, R4/R5 writes, R7 halt
        for (int v = 0; v < 6; v++) begin
            do_reset();
            sel = VEC[v][39:37];
            lat = int'(VEC[v][35:32]);
            cdata = VEC[v][31:0];
            repeat (5) @(negedge clk);
            if (VEC[v][36] == 1'b0) begin
                warn = 1'b1;
                repeat (2) @(posedge clk);
                @(negedge clk);
                check(drive_en == 1'b1, "R2 drive before sync", int'(drive_en), 1);
                @(posedge clk);
                @(negedge clk);
                check(drive_en == 1'b0, "R2 drive off at third edge", int'(drive_en), 0);
            end else begin
                mains_run = 1'b0;
                repeat (150) @(negedge clk);
                check(drive_en == 1'b1, "R3 within window", int'(drive_en), 1);
            end
            wait_halt("R7 halted");
            check_writes(VEC[v][39:37], VEC[v][31:0], "R5 data order");
            check(drive_en == 1'b0, "R2 safe after save", int'(drive_en), 0);
        end

        // R8 snapshot, R9 warning re-pulsed mid save and after halt
        do_reset();
        sel = 3'd4; cdata = 32'hCAFEF00D; lat = 6;
        repeat (3) @(negedge clk);
        warn = 1'b1;
        repeat (4) @(negedge clk);
        sel = 3'd6; cdata = 32'h99999999;
        warn = 1'b0;
        repeat (10) @(negedge clk);
        warn = 1'b1;
        wait_halt("R9 halted");
        check_writes(3'd4, 32'hCAFEF00D, "R8 snapshot data");
        warn = 1'b0;
        repeat (20) @(negedge clk);
        warn = 1'b1;
        repeat (200) @(negedge clk);
        check(wr_cnt == NB && nv_req == 1'b0, "R9 no write after halt", wr_cnt, NB);
        check(drive_en == 1'b0, "R9 drive stays off", int'(drive_en), 0);

        // R6 external busy holds off the first request
        do_reset();
        sel = 3'd2; cdata = 32'h5A6B7C8D; lat = 2;
        hold_busy = 1'b1;
        repeat (3) @(negedge clk);
        warn = 1'b1;
        repeat (60) @(negedge clk);
        check(nv_req == 1'b0 && wr_cnt == 0, "R6 no req while busy", wr_cnt, 0);
        check(drive_en == 1'b0, "R2 safe while waiting", int'(drive_en), 0);
        hold_busy = 1'b0;
        wait_halt("R6 halted");
        check_writes(3'd2, 32'h5A6B7C8D, "R6 data after busy");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule